// File: doc/BRIEF.md
# Seek Completion Interrupt Reporter

This block holds the interrupt and status state behind a disk controller's command sequencer. Single-cycle pulses mark three kinds of event. The first is the end of a seek or recalibrate on a given drive, with a normal or abnormal outcome. The second is entry into a command's result phase. The third is a request to move a data byte by programmed I/O, without DMA. Any of these events raises the interrupt output. A seek completion also keeps its drive marked busy until software collects it. Seek-type commands produce no result bytes of their own. Their status therefore waits in the block until a sense-interrupt strobe arrives.

A sense-interrupt strobe makes the block report the oldest-numbered pending seek completion. It sends a status byte followed by that drive's present cylinder number, then clears that cause. When no seek completion is pending, the block returns a single invalid-command status byte and clears any other interrupt cause. The result bytes leave through a valid/ready handshake. The sequencer keeps each drive's present cylinder in the block through a write port.

While the power-down input is high, the block ignores all events, writes and strobes. Leaving power-down wipes the stored cylinders, busy flags and interrupt causes.

Top module: `sk_irq_reporter`

## Requirements
- R1: A `seek_done_i` pulse sets `busy_o[drv_sel_i]` and drives `irq_o` high from the next clock edge.
- R2: A `result_entry_i` or `ndma_req_i` pulse drives `irq_o` high from the next edge and leaves `busy_o` unchanged.
- R3: `irq_o` stays high while any busy bit is set or a non-seek cause is uncollected. It falls only once a sense strobe has cleared the last cause.
- R4: Status byte layout: bits 7:6 hold the interrupt code, bit 5 is the seek-end flag, bits 4 and 3 are zero, bit 2 (head) is always zero, and bits 1:0 give the drive. A normal completion gives code 00 with seek-end 1, and an abnormal one gives code 01 with seek-end 1.
- R5: After the status byte of a seek report comes a second byte: the value last written through `pcn_we_i`/`pcn_i` for that drive. The report then clears that drive's busy bit.
- R6: A sense strobe with no seek pending returns exactly one byte, 0x80 (code 10, seek-end 0). It also clears the result-entry and non-DMA causes.
- R7: When several drives are pending, each sense reports only one drive, and the lowest-numbered pending drive goes first.
- R8: A seek completion that arrives in the same cycle as an accepted sense for the same drive does not change the report: the report carries the earlier outcome and cylinder. The new completion stays pending.
- R9: A sense strobe that arrives while result bytes are still outstanding is ignored.
- R10: While `res_valid_o` is high and `res_ready_i` is low, `res_data_o` and `res_valid_o` hold. A byte is consumed on the edge where valid and ready are both high.
- R11: While `pwr_down_i` is high, and in the first cycle after it falls, the block ignores event pulses, cylinder writes and sense strobes, so `busy_o` holds.
- R12: When `pwr_down_i` falls, every busy bit, every interrupt cause and every stored cylinder is cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| drv_sel_i | input | 2 | Drive addressed by seek_done_i and pcn_we_i |
| seek_done_i | input | 1 | Seek/recalibrate finished on drv_sel_i |
| seek_abn_i | input | 1 | Outcome qualifier for seek_done_i: 1 = abnormal |
| pcn_we_i | input | 1 | Write pcn_i as the present cylinder of drv_sel_i |
| pcn_i | input | CYL_W | Present cylinder value |
| result_entry_i | input | 1 | A command entered its result phase |
| ndma_req_i | input | 1 | Programmed-I/O byte transfer needed |
| sense_i | input | 1 | Sense-interrupt command strobe |
| pwr_down_i | input | 1 | Power-down level |
| irq_o | output | 1 | Interrupt request |
| busy_o | output | NUM_DRIVES | Drive holds an uncollected seek completion |
| res_valid_o | output | 1 | Result byte valid |
| res_data_o | output | CYL_W | Result byte |
| res_ready_i | input | 1 | Consumer takes the result byte |

## Verification
Two functions can fall in the same cycle. A sense strobe can collect drive 0 while a fresh seek completion for drive 0, with a new cylinder write, lands on the same edge. The bench raises both in one cycle. It then checks three things: the report carries the earlier normal code and cylinder, drive 0 stays busy with the interrupt high, and a second sense returns the abnormal code and the new cylinder. A second overlap is a sense strobe that arrives while a result byte is stalled. The bench holds ready low and checks that the stalled byte keeps its value and that no extra result follows.

// File: rtl/sk_irq_pkg.sv
package sk_irq_pkg;
  localparam int DRV_W = 2;

  localparam logic [1:0] IC_NORM  = 2'b00;
  localparam logic [1:0] IC_ABN   = 2'b01;
  localparam logic [1:0] IC_INVAL = 2'b10;

  typedef enum logic [1:0] {
    RS_IDLE = 2'd0,
    RS_ST0  = 2'd1,
    RS_CYL  = 2'd2
  } rs_state_e;

  // Status byte: code, seek-end, two zero flags, head (always 0), drive
  function automatic logic [7:0] mk_status(input logic [1:0] ic,
                                           input logic se,
                                           input logic [DRV_W-1:0] drv);
    return {ic, se, 1'b0, 1'b0, 1'b0, drv};
  endfunction
endpackage

// File: rtl/sk_pend_table.sv
module sk_pend_table
  import sk_irq_pkg::*;
#(
  parameter int NUM_DRIVES = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  set_v,
  input  logic [DRV_W-1:0]      set_drv,
  input  logic                  set_abn,
  input  logic                  clr_v,
  input  logic [DRV_W-1:0]      clr_drv,
  input  logic                  wipe,
  output logic [NUM_DRIVES-1:0] pend_q,
  output logic [NUM_DRIVES-1:0] pend_d,
  output logic                  any_pend,
  output logic [DRV_W-1:0]      sel_drv,
  output logic                  sel_abn
);
  logic [NUM_DRIVES-1:0] abn_q, abn_d;

  // Clear first, then set: a completion in the collecting cycle survives
  always_comb begin
    pend_d = pend_q;
    abn_d  = abn_q;
    if (wipe) begin
      pend_d = '0;
      abn_d  = '0;
    end else begin
      if (clr_v) pend_d[clr_drv] = 1'b0;
      if (set_v) begin
        pend_d[set_drv] = 1'b1;
        abn_d[set_drv]  = set_abn;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      abn_q  <= '0;
    end else begin
      pend_q <= pend_d;
      abn_q  <= abn_d;
    end
  end

  // Lowest-numbered pending drive wins
  always_comb begin
    sel_drv = '0;
    for (int i = NUM_DRIVES - 1; i >= 0; i--) begin
      if (pend_q[i]) sel_drv = DRV_W'(i);
    end
  end

  assign sel_abn  = abn_q[sel_drv];
  assign any_pend = |pend_q;
endmodule

// File: rtl/sk_cyl_store.sv
module sk_cyl_store
  import sk_irq_pkg::*;
#(
  parameter int NUM_DRIVES = 4,
  parameter int CYL_W      = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wipe,
  input  logic             we,
  input  logic [DRV_W-1:0] waddr,
  input  logic [CYL_W-1:0] wdata,
  input  logic             rd_en,
  input  logic [DRV_W-1:0] raddr,
  output logic [CYL_W-1:0] rd_q
);
  logic [CYL_W-1:0] mem [NUM_DRIVES];

  always_ff @(posedge clk) begin
    if (rst || wipe) begin
      for (int i = 0; i < NUM_DRIVES; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  // Read-first capture: sees the value from before a same-edge write
  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else if (rd_en) rd_q <= mem[raddr];
  end
endmodule

// File: rtl/sk_result_seq.sv
module sk_result_seq
  import sk_irq_pkg::*;
#(
  parameter int CYL_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             rep_seek,
  input  logic [1:0]       ic,
  input  logic [DRV_W-1:0] drv,
  input  logic [CYL_W-1:0] cyl_rd,
  input  logic             ready,
  output logic             valid,
  output logic [CYL_W-1:0] data,
  output logic             first,
  output logic             idle
);
  rs_state_e state_q;
  logic      two_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= RS_IDLE;
      valid   <= 1'b0;
      data    <= '0;
      first   <= 1'b0;
      two_q   <= 1'b0;
    end else begin
      unique case (state_q)
        RS_IDLE: begin
          if (start) begin
            state_q <= RS_ST0;
            valid   <= 1'b1;
            first   <= 1'b1;
            two_q   <= rep_seek;
            data    <= rep_seek ? CYL_W'(mk_status(ic, 1'b1, drv))
                                : CYL_W'(mk_status(IC_INVAL, 1'b0, '0));
          end
        end
        RS_ST0: begin
          if (ready) begin
            first <= 1'b0;
            if (two_q) begin
              state_q <= RS_CYL;
              data    <= cyl_rd;
            end else begin
              state_q <= RS_IDLE;
              valid   <= 1'b0;
            end
          end
        end
        RS_CYL: begin
          if (ready) begin
            state_q <= RS_IDLE;
            valid   <= 1'b0;
          end
        end
        default: state_q <= RS_IDLE;
      endcase
    end
  end

  assign idle = (state_q == RS_IDLE);
endmodule

// File: rtl/sk_irq_reporter.sv
module sk_irq_reporter
  import sk_irq_pkg::*;
#(
  parameter int NUM_DRIVES = 4,
  parameter int CYL_W      = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [DRV_W-1:0]      drv_sel_i,
  input  logic                  seek_done_i,
  input  logic                  seek_abn_i,
  input  logic                  pcn_we_i,
  input  logic [CYL_W-1:0]      pcn_i,
  input  logic                  result_entry_i,
  input  logic                  ndma_req_i,
  input  logic                  sense_i,
  input  logic                  pwr_down_i,
  output logic                  irq_o,
  output logic [NUM_DRIVES-1:0] busy_o,
  output logic                  res_valid_o,
  output logic [CYL_W-1:0]      res_data_o,
  input  logic                  res_ready_i
);
  logic                  pwr_q;
  logic                  active, wipe, accept;
  logic [NUM_DRIVES-1:0] pend_q, pend_d;
  logic                  any_pend, sel_abn, seq_idle, res_first;
  logic [DRV_W-1:0]      sel_drv;
  logic [CYL_W-1:0]      cyl_rd;
  logic                  other_q, other_d, irq_q;

  assign active = ~pwr_down_i & ~pwr_q;
  assign wipe   = pwr_q & ~pwr_down_i;
  assign accept = sense_i & active & seq_idle;

  sk_pend_table #(.NUM_DRIVES(NUM_DRIVES)) u_pend (
    .clk     (clk),
    .rst     (rst),
    .set_v   (seek_done_i & active),
    .set_drv (drv_sel_i),
    .set_abn (seek_abn_i),
    .clr_v   (accept & any_pend),
    .clr_drv (sel_drv),
    .wipe    (wipe),
    .pend_q  (pend_q),
    .pend_d  (pend_d),
    .any_pend(any_pend),
    .sel_drv (sel_drv),
    .sel_abn (sel_abn)
  );

  sk_cyl_store #(.NUM_DRIVES(NUM_DRIVES), .CYL_W(CYL_W)) u_cyl (
    .clk  (clk),
    .rst  (rst),
    .wipe (wipe),
    .we   (pcn_we_i & active),
    .waddr(drv_sel_i),
    .wdata(pcn_i),
    .rd_en(accept),
    .raddr(sel_drv),
    .rd_q (cyl_rd)
  );

  sk_result_seq #(.CYL_W(CYL_W)) u_seq (
    .clk     (clk),
    .rst     (rst),
    .start   (accept),
    .rep_seek(any_pend),
    .ic      (sel_abn ? IC_ABN : IC_NORM),
    .drv     (sel_drv),
    .cyl_rd  (cyl_rd),
    .ready   (res_ready_i),
    .valid   (res_valid_o),
    .data    (res_data_o),
    .first   (res_first),
    .idle    (seq_idle)
  );

  always_comb begin
    if (wipe) other_d = 1'b0;
    else      other_d = (other_q & ~accept) |
                        ((result_entry_i | ndma_req_i) & active);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pwr_q   <= 1'b0;
      other_q <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      pwr_q   <= pwr_down_i;
      other_q <= other_d;
      irq_q   <= (|pend_d) | other_d;
    end
  end

  assign irq_o  = irq_q;
  assign busy_o = pend_q;
endmodule

// File: rtl/sk_irq_reporter_chk.sv
module sk_irq_reporter_chk #(
  parameter int NUM_DRIVES = 4,
  parameter int CYL_W      = 8
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  seek_done_i,
  input logic                  result_entry_i,
  input logic                  ndma_req_i,
  input logic                  pwr_down_i,
  input logic                  irq_o,
  input logic [NUM_DRIVES-1:0] busy_o,
  input logic                  res_valid_o,
  input logic                  res_ready_i,
  input logic [CYL_W-1:0]      res_data_o,
  input logic                  res_first
);
  p_event_irq_r1: assert property (@(posedge clk) disable iff (rst)
    ((seek_done_i | result_entry_i | ndma_req_i) & ~pwr_down_i & ~$past(pwr_down_i))
      |=> irq_o);

  p_busy_holds_irq_r3: assert property (@(posedge clk) disable iff (rst)
    (|busy_o) |-> irq_o);

  p_status_zero_bits_r4: assert property (@(posedge clk) disable iff (rst)
    (res_valid_o & res_first) |-> (res_data_o[4:2] == 3'b000));

  p_stall_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (res_valid_o & ~res_ready_i) |=> (res_valid_o & $stable(res_data_o)));

  p_pd_frozen_r11: assert property (@(posedge clk) disable iff (rst)
    pwr_down_i |=> $stable(busy_o));
endmodule

bind sk_irq_reporter sk_irq_reporter_chk #(.NUM_DRIVES(NUM_DRIVES), .CYL_W(CYL_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .seek_done_i   (seek_done_i),
  .result_entry_i(result_entry_i),
  .ndma_req_i    (ndma_req_i),
  .pwr_down_i    (pwr_down_i),
  .irq_o         (irq_o),
  .busy_o        (busy_o),
  .res_valid_o   (res_valid_o),
  .res_ready_i   (res_ready_i),
  .res_data_o    (res_data_o),
  .res_first     (res_first)
);

// File: tb/sk_irq_reporter_bench.sv
`timescale 1ns/1ps
module sk_irq_reporter_bench;
  localparam int ND = 4;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [1:0]    drv_sel_i = '0;
  logic          seek_done_i = 0, seek_abn_i = 0, pcn_we_i = 0;
  logic [CW-1:0] pcn_i = '0;
  logic          result_entry_i = 0, ndma_req_i = 0, sense_i = 0, pwr_down_i = 0;
  logic          irq_o, res_valid_o, res_ready_i = 0;
  logic [ND-1:0] busy_o;
  logic [CW-1:0] res_data_o;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  sk_irq_reporter #(.NUM_DRIVES(ND), .CYL_W(CW)) u_sk_irq_reporter (
    .clk(clk), .rst(rst), .drv_sel_i(drv_sel_i), .seek_done_i(seek_done_i),
    .seek_abn_i(seek_abn_i), .pcn_we_i(pcn_we_i), .pcn_i(pcn_i),
    .result_entry_i(result_entry_i), .ndma_req_i(ndma_req_i), .sense_i(sense_i),
    .pwr_down_i(pwr_down_i), .irq_o(irq_o), .busy_o(busy_o),
    .res_valid_o(res_valid_o), .res_data_o(res_data_o), .res_ready_i(res_ready_i)
  );

  // {drive[1:0], abnormal, cylinder[7:0], expected status[7:0]}
  localparam logic [18:0] VEC [6] = '{
    {2'd0, 1'b0, 8'h00, 8'h20},
    {2'd1, 1'b1, 8'h4F, 8'h61},
    {2'd2, 1'b0, 8'hFF, 8'h22},
    {2'd3, 1'b1, 8'h12, 8'h63},
    {2'd3, 1'b0, 8'h80, 8'h23},
    {2'd1, 1'b0, 8'h07, 8'h21}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic seek(input logic [1:0] d, input logic abn, input logic we, input logic [7:0] c);
    drv_sel_i = d; seek_done_i = 1; seek_abn_i = abn; pcn_we_i = we; pcn_i = c;
    @(negedge clk);
    seek_done_i = 0; seek_abn_i = 0; pcn_we_i = 0;
  endtask

  task automatic do_sense(output int n, output logic [7:0] b0, output logic [7:0] b1);
    n = 0; b0 = '0; b1 = '0;
    sense_i = 1;
    @(negedge clk);
    sense_i = 0;
    if (res_valid_o) begin n = 1; b0 = res_data_o; end
    res_ready_i = 1;
    @(negedge clk);
    if (res_valid_o) begin
      n = 2; b1 = res_data_o;
      @(negedge clk);
    end
    res_ready_i = 0;
  endtask

  initial begin
    int n;
    logic [7:0] b0, b1;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("reset irq", irq_o, 0);
    chk("reset busy", busy_o, 0);
    chk("reset valid", res_valid_o, 0);

    // Table walk: one completion per entry, then collect it
    foreach (VEC[i]) begin
      seek(VEC[i][18:17], VEC[i][16], 1'b1, VEC[i][15:8]);
      chk("R1 irq after seek", irq_o, 1);
      chk("R1 busy bit", busy_o, 32'(1) << VEC[i][18:17]);
      do_sense(n, b0, b1);
      chk("R4 status byte", b0, VEC[i][7:0]);
      chk("R5 cylinder byte", b1, VEC[i][15:8]);
      chk("R5 two bytes", n, 2);
      chk("R5 busy cleared", busy_o, 0);
      chk("R3 irq dropped", irq_o, 0);
    end

    // R6: nothing pending
    do_sense(n, b0, b1);
    chk("R6 single byte", n, 1);
    chk("R6 invalid code", b0, 8'h80);

    // R2: non-seek causes
    result_entry_i = 1; @(negedge clk); result_entry_i = 0;
    chk("R2 irq on result entry", irq_o, 1);
    chk("R2 busy untouched", busy_o, 0);
    do_sense(n, b0, b1);
    chk("R6 byte after result entry", b0, 8'h80);
    chk("R6 irq cleared", irq_o, 0);
    ndma_req_i = 1; @(negedge clk); ndma_req_i = 0;
    chk("R2 irq on ndma", irq_o, 1);
    do_sense(n, b0, b1);
    chk("R6 count after ndma", n, 1);
    chk("R6 irq cleared ndma", irq_o, 0);

    // R7: priority, one drive per sense
    seek(2'd3, 1'b0, 1'b1, 8'h33);
    seek(2'd1, 1'b1, 1'b1, 8'h11);
    do_sense(n, b0, b1);
    chk("R7 lower drive first", b0, 8'h61);
    chk("R7 its cylinder", b1, 8'h11);
    chk("R3 irq held", irq_o, 1);
    chk("R7 other still busy", busy_o, 4'b1000);
    do_sense(n, b0, b1);
    chk("R7 second drive", b0, 8'h23);
    chk("R7 second cylinder", b1, 8'h33);
    chk("R3 irq low", irq_o, 0);

    // R8: completion collides with sense for the same drive
    seek(2'd0, 1'b0, 1'b1, 8'h05);
    sense_i = 1; drv_sel_i = 2'd0; seek_done_i = 1; seek_abn_i = 1; pcn_we_i = 1; pcn_i = 8'h06;
    @(negedge clk);
    sense_i = 0; seek_done_i = 0; seek_abn_i = 0; pcn_we_i = 0;
    chk("R8 old status", res_data_o, 8'h20);
    res_ready_i = 1; @(negedge clk);
    chk("R8 old cylinder", res_data_o, 8'h05);
    @(negedge clk); res_ready_i = 0;
    chk("R8 still busy", busy_o, 4'b0001);
    chk("R8 irq high", irq_o, 1);
    do_sense(n, b0, b1);
    chk("R8 new status", b0, 8'h60);
    chk("R8 new cylinder", b1, 8'h06);

    // R9/R10: stall and a stray sense
    seek(2'd2, 1'b0, 1'b1, 8'h2A);
    sense_i = 1; @(negedge clk); sense_i = 0;
    @(negedge clk);
    chk("R10 valid held", res_valid_o, 1);
    chk("R10 data held", res_data_o, 8'h22);
    sense_i = 1; @(negedge clk); sense_i = 0;
    chk("R9 data unchanged", res_data_o, 8'h22);
    res_ready_i = 1; @(negedge clk);
    chk("R10 second byte", res_data_o, 8'h2A);
    @(negedge clk); res_ready_i = 0;
    chk("R9 no extra result", res_valid_o, 0);
    @(negedge clk);
    chk("R9 still idle", res_valid_o, 0);

    // R11/R12: power-down
    seek(2'd2, 1'b0, 1'b1, 8'h40);
    pwr_down_i = 1; @(negedge clk);
    seek(2'd1, 1'b1, 1'b1, 8'h55);
    sense_i = 1; @(negedge clk); sense_i = 0;
    @(negedge clk);
    chk("R11 sense ignored", res_valid_o, 0);
    chk("R11 busy frozen", busy_o, 4'b0100);
    pwr_down_i = 0; @(negedge clk);
    chk("R12 busy wiped", busy_o, 0);
    chk("R12 irq wiped", irq_o, 0);
    seek(2'd2, 1'b0, 1'b0, 8'h00);
    do_sense(n, b0, b1);
    chk("R12 status after wake", b0, 8'h22);
    chk("R12 cylinder zeroed", b1, 8'h00);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule